// File: doc/BRIEF.md
# Far Jump Target Resolver

This block settles where a protected-mode far jump lands. A caller hands it the target selector, the offset taken from the instruction, the operand-size flag and the current privilege level, and pulses `start`. The resolver asks a descriptor-table read port for the descriptor named by the selector. It classifies that descriptor and then takes one of four paths. It can load a code segment at once. It can follow a call gate, which needs a second read for the gate's target code segment. It can hand a TSS selector to a task-switch engine. Or it can report a general-protection fault.

Each outcome is announced by a one-cycle `done` pulse together with exactly one of `jmp_load`, `task_req` or `fault`. The new code selector and offset stay on `tgt_sel` and `tgt_off` until the next successful jump. The TSS selector stays on `tss_sel` until the next task switch. No transfer ever changes the privilege level: every loaded selector carries the current level in its two low bits.

Descriptors use a 64-bit layout. Bit 47 is present and bits 46:45 are the descriptor privilege level. Bit 44 is set for code/data segments and clear for system descriptors. Bits 43:40 hold the type. In a gate, bits 31:16 hold a selector, and the offset is split between bits 63:48 (high half) and bits 15:0 (low half).

Top module: `farjmp_resolver`

## Requirements
- R1: A request drives `dreq_local` from selector bit 2 (set means local table) and `dreq_index` from selector bits 15:3. It holds `dreq_valid` and those fields steady until `dreq_ready` is seen. Data on `drsp_data` is taken in the cycle of that handshake.
- R2: A present non-conforming code segment (bit 44 set, type bit 3 set, type bit 2 clear) whose level equals the current level gives `jmp_load`. The target is the instruction's selector with bits 1:0 replaced by the current level, plus the instruction's offset. At any other level it gives `fault`.
- R3: With `op32` low, bits 31:16 of a loaded instruction offset are zero. With `op32` high, all 32 bits pass.
- R4: A present conforming code segment (type bit 2 set) is accepted when its level is numerically at most the current level, and faults otherwise.
- R5: A present call gate (system type 4 for 16-bit, type 12 for 32-bit) causes a second request for the gate's selector (bits 31:16). The jump then loads that selector, with the current level in bits 1:0, and the gate's offset. A 16-bit gate keeps only the low half of that offset. The instruction's offset is ignored.
- R6: The descriptor returned for a call gate's target must be a present code segment that passes R2 or R4 against the current level; otherwise the outcome is `fault`.
- R7: A present task gate (system type 5) gives `task_req` with `tss_sel` taken from the gate's bits 31:16.
- R8: A present available TSS (system type 1 or 9) gives `task_req` with `tss_sel` equal to the instruction's selector.
- R9: A descriptor whose present bit is clear, a data segment, a busy TSS (type 11) or any other system type gives `fault`. `tgt_sel`, `tgt_off` and `tss_sel` keep their previous values.
- R10: Every resolution ends in a single-cycle `done` with exactly one of `jmp_load`, `task_req`, `fault`. These three stay low whenever `done` is low.
- R11: Counting clock edges from the one that samples `start`, `done` is visible after edge 3 plus the wait cycles of the first request. A call gate that reaches its second read takes one more edge plus that read's wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a resolution (accepted when idle) |
| sel_in | input | 16 | Target selector from the instruction |
| off_in | input | 32 | Target offset from the instruction |
| op32 | input | 1 | Operand size is 32 bits |
| cpl | input | 2 | Current privilege level |
| dreq_valid | output | 1 | Descriptor read request |
| dreq_ready | input | 1 | Read accepted; data valid this cycle |
| dreq_local | output | 1 | Read from local (1) or global (0) table |
| dreq_index | output | 13 | Descriptor index |
| drsp_data | input | 64 | Descriptor returned by the table |
| done | output | 1 | Resolution finished (one cycle) |
| jmp_load | output | 1 | Code segment target loaded |
| task_req | output | 1 | Task switch requested |
| fault | output | 1 | General-protection fault |
| tgt_sel | output | 16 | New code selector |
| tgt_off | output | 32 | New code offset |
| tss_sel | output | 16 | Selector of the TSS to switch to |

## Verification
`done` is due after edge 3 plus the programmed wait of the first read, counted from the edge that samples `start`. The gate path adds one edge and the second read's wait. The bench computes this due cycle for each case from the descriptor kind and the responder delay, and compares it with the edge count at which `done` first appears. The outcome flags and target fields are sampled on the falling edge of that same cycle. `done` is checked low again one cycle later, so a late or stretched pulse is caught as well as a missing one.

// File: rtl/fjd_pkg.sv
package fjd_pkg;
   localparam int DESC_W   = 64;
   localparam int ATTR_LO  = 40;
   localparam int ATTR_W   = 8;
   localparam int GSEL_LO  = 16;

   typedef enum logic [2:0] {
      K_BAD, K_CODE, K_CGATE16, K_CGATE32, K_TGATE, K_TSS
   } dkind_t;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH_DESC, S_DECIDE, S_FETCH_GATE_TARGET, S_DONE, S_FAULT
   } fsm_t;
endpackage

// File: rtl/fjd_classify.sv
module fjd_classify
   import fjd_pkg::*;
(
   input  logic [ATTR_W-1:0] attr,
   input  logic [1:0]        cpl,
   output dkind_t            kind
);
   logic       present;
   logic       seg;
   logic [1:0] dpl;
   logic [3:0] ty;

   always_comb begin
      present = attr[7];
      dpl     = attr[6:5];
      seg     = attr[4];
      ty      = attr[3:0];
      kind    = K_BAD;
      if (present) begin
         if (seg) begin
            if (ty[3] && (ty[2] ? (dpl <= cpl) : (dpl == cpl)))
               kind = K_CODE;
         end else begin
            case (ty)
               4'h4:       kind = K_CGATE16;
               4'hC:       kind = K_CGATE32;
               4'h5:       kind = K_TGATE;
               4'h1, 4'h9: kind = K_TSS;
               default:    kind = K_BAD;
            endcase
         end
      end
   end
endmodule

// File: rtl/fjd_offset.sv
module fjd_offset #(
   parameter int OFF_W = 32
) (
   input  logic [OFF_W-1:0] raw,
   input  logic             wide,
   output logic [OFF_W-1:0] sized
);
   generate
      if (OFF_W > 16) begin : g_wide
         assign sized = wide ? raw : {{(OFF_W-16){1'b0}}, raw[15:0]};
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide;
         assign sized       = raw;
      end
   endgenerate
endmodule

// File: rtl/farjmp_resolver.sv
module farjmp_resolver
   import fjd_pkg::*;
#(
   parameter int SEL_W = 16,
   parameter int OFF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SEL_W-1:0]  sel_in,
   input  logic [OFF_W-1:0]  off_in,
   input  logic              op32,
   input  logic [1:0]        cpl,
   output logic              dreq_valid,
   input  logic              dreq_ready,
   output logic              dreq_local,
   output logic [SEL_W-4:0]  dreq_index,
   input  logic [DESC_W-1:0] drsp_data,
   output logic              done,
   output logic              jmp_load,
   output logic              task_req,
   output logic              fault,
   output logic [SEL_W-1:0]  tgt_sel,
   output logic [OFF_W-1:0]  tgt_off,
   output logic [SEL_W-1:0]  tss_sel
);
   localparam int IDX_W = SEL_W - 3;

   generate
      if (SEL_W != 16) begin : g_bad_sel
         $error("farjmp_resolver: SEL_W must be 16");
      end
      if (OFF_W != 16 && OFF_W != 32) begin : g_bad_off
         $error("farjmp_resolver: OFF_W must be 16 or 32");
      end
   endgenerate

   fsm_t              st;
   logic [SEL_W-1:0]  sel_q;
   logic [OFF_W-1:0]  off_q;
   logic              op32_q;
   logic [1:0]        cpl_q;
   logic [DESC_W-1:0] desc_q;
   logic              is_task_q;
   logic [SEL_W-1:0]  tgt_sel_q;
   logic [OFF_W-1:0]  tgt_off_q;
   logic [SEL_W-1:0]  tss_q;

   logic [SEL_W-1:0]  gate_sel;
   logic [SEL_W-1:0]  req_sel;
   logic [31:0]       gate_raw;
   logic [OFF_W-1:0]  insn_off;
   logic [OFF_W-1:0]  gate_off;
   logic [ATTR_W-1:0] cls_attr [2];
   dkind_t            kinds [2];
   logic              unused_bits;

   assign gate_sel    = desc_q[GSEL_LO +: SEL_W];
   assign gate_raw    = {desc_q[63:48], desc_q[15:0]};
   assign unused_bits = ^desc_q[39:32];
   assign req_sel     = (st == S_FETCH_GATE_TARGET) ? gate_sel : sel_q;
   assign dreq_valid  = (st == S_FETCH_DESC) || (st == S_FETCH_GATE_TARGET);
   assign dreq_local  = req_sel[2];
   assign dreq_index  = req_sel[SEL_W-1 -: IDX_W];

   assign cls_attr[0] = desc_q[ATTR_LO +: ATTR_W];
   assign cls_attr[1] = drsp_data[ATTR_LO +: ATTR_W];

   generate
      for (genvar g = 0; g < 2; g++) begin : g_cls
         fjd_classify u_cls (
            .attr (cls_attr[g]),
            .cpl  (cpl_q),
            .kind (kinds[g])
         );
      end
   endgenerate

   fjd_offset #(.OFF_W(OFF_W)) u_off_insn (
      .raw   (off_q),
      .wide  (op32_q),
      .sized (insn_off)
   );

   fjd_offset #(.OFF_W(OFF_W)) u_off_gate (
      .raw   (gate_raw[OFF_W-1:0]),
      .wide  (kinds[0] == K_CGATE32),
      .sized (gate_off)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         sel_q     <= '0;
         off_q     <= '0;
         op32_q    <= 1'b0;
         cpl_q     <= '0;
         desc_q    <= '0;
         is_task_q <= 1'b0;
         tgt_sel_q <= '0;
         tgt_off_q <= '0;
         tss_q     <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (start) begin
                  sel_q  <= sel_in;
                  off_q  <= off_in;
                  op32_q <= op32;
                  cpl_q  <= cpl;
                  st     <= S_FETCH_DESC;
               end
            end
            S_FETCH_DESC: begin
               if (dreq_ready) begin
                  desc_q <= drsp_data;
                  st     <= S_DECIDE;
               end
            end
            S_DECIDE: begin
               case (kinds[0])
                  K_CODE: begin
                     tgt_sel_q <= {sel_q[SEL_W-1:2], cpl_q};
                     tgt_off_q <= insn_off;
                     is_task_q <= 1'b0;
                     st        <= S_DONE;
                  end
                  K_CGATE16, K_CGATE32: st <= S_FETCH_GATE_TARGET;
                  K_TGATE: begin
                     tss_q     <= gate_sel;
                     is_task_q <= 1'b1;
                     st        <= S_DONE;
                  end
                  K_TSS: begin
                     tss_q     <= sel_q;
                     is_task_q <= 1'b1;
                     st        <= S_DONE;
                  end
                  default: st <= S_FAULT;
               endcase
            end
            S_FETCH_GATE_TARGET: begin
               if (dreq_ready) begin
                  if (kinds[1] == K_CODE) begin
                     tgt_sel_q <= {gate_sel[SEL_W-1:2], cpl_q};
                     tgt_off_q <= gate_off;
                     is_task_q <= 1'b0;
                     st        <= S_DONE;
                  end else begin
                     st <= S_FAULT;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign done     = (st == S_DONE) || (st == S_FAULT);
   assign fault    = (st == S_FAULT);
   assign jmp_load = (st == S_DONE) && !is_task_q;
   assign task_req = (st == S_DONE) && is_task_q;
   assign tgt_sel  = tgt_sel_q;
   assign tgt_off  = tgt_off_q;
   assign tss_sel  = tss_q;
endmodule

// File: rtl/fjd_checker.sv
module fjd_checker #(
   parameter int SEL_W = 16,
   parameter int OFF_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dreq_valid,
   input logic             dreq_ready,
   input logic             dreq_local,
   input logic [SEL_W-4:0] dreq_index,
   input logic             done,
   input logic             jmp_load,
   input logic             task_req,
   input logic             fault,
   input logic [SEL_W-1:0] tgt_sel,
   input logic [OFF_W-1:0] tgt_off,
   input logic [SEL_W-1:0] tss_sel
);
   a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_index) && $stable(dreq_local));

   a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $countones({jmp_load, task_req, fault}) == 1);

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !jmp_load && !task_req && !fault);

   a_r9_fault_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $stable(tgt_sel) && $stable(tgt_off) && $stable(tss_sel));

   a_r7_task_keeps_jump: assert property (@(posedge clk) disable iff (!rst_n)
      task_req |-> $stable(tgt_sel) && $stable(tgt_off));

   a_r2_jump_keeps_tss: assert property (@(posedge clk) disable iff (!rst_n)
      jmp_load |-> $stable(tss_sel));
endmodule

bind farjmp_resolver fjd_checker #(.SEL_W(SEL_W), .OFF_W(OFF_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dreq_valid (dreq_valid),
   .dreq_ready (dreq_ready),
   .dreq_local (dreq_local),
   .dreq_index (dreq_index),
   .done       (done),
   .jmp_load   (jmp_load),
   .task_req   (task_req),
   .fault      (fault),
   .tgt_sel    (tgt_sel),
   .tgt_off    (tgt_off),
   .tss_sel    (tss_sel)
);

// File: tb/farjmp_resolver_test.sv
`timescale 1ns/1ps
module farjmp_resolver_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] sel_in = '0;
   logic [31:0] off_in = '0;
   logic        op32 = 1'b0;
   logic [1:0]  cpl = '0;
   logic        dreq_valid;
   logic        dreq_ready = 1'b0;
   logic        dreq_local;
   logic [12:0] dreq_index;
   logic [63:0] drsp_data = '0;
   logic        done, jmp_load, task_req, fault;
   logic [15:0] tgt_sel, tss_sel;
   logic [31:0] tgt_off;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int delay = 0;
   int wait_cnt = 0;
   int nreq = 0;
   logic [63:0] cur_d [2];
   logic        req_loc [2];
   logic [12:0] req_idx [2];

   logic [15:0] e_sel = '0;
   logic [31:0] e_off = '0;
   logic [15:0] e_tss = '0;

   always #10 clk = ~clk;

   farjmp_resolver uut (
      .clk(clk), .rst_n(rst_n), .start(start), .sel_in(sel_in), .off_in(off_in),
      .op32(op32), .cpl(cpl), .dreq_valid(dreq_valid), .dreq_ready(dreq_ready),
      .dreq_local(dreq_local), .dreq_index(dreq_index), .drsp_data(drsp_data),
      .done(done), .jmp_load(jmp_load), .task_req(task_req), .fault(fault),
      .tgt_sel(tgt_sel), .tgt_off(tgt_off), .tss_sel(tss_sel)
   );

   // descriptor table responder, waits `delay` falling edges before ready
   always @(negedge clk) begin
      if (dreq_valid && !dreq_ready) begin
         if (wait_cnt == delay) begin
            dreq_ready = 1'b1;
            if (nreq < 2) begin
               drsp_data    = cur_d[nreq];
               req_loc[nreq] = dreq_local;
               req_idx[nreq] = dreq_index;
            end else begin
               drsp_data = '0;
            end
            nreq++;
         end else begin
            wait_cnt++;
         end
      end else begin
         dreq_ready = 1'b0;
         wait_cnt   = 0;
      end
   end

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            report();
         end
      end
   end

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_desc(input logic p, input logic [1:0] dpl,
         input logic s, input logic [3:0] ty, input logic [15:0] gs, input logic [31:0] go);
      return {go[31:16], p, dpl, s, ty, 8'h00, gs, go[15:0]};
   endfunction

   function automatic logic code_ok(input logic p, input logic s, input logic [3:0] ty,
         input logic [1:0] dpl, input logic [1:0] c);
      if (!p || !s || !ty[3]) return 1'b0;
      return ty[2] ? (dpl <= c) : (dpl == c);
   endfunction

   // kinds: 0 code nc, 1 code conf, 2 data, 3 gate16, 4 gate32, 5 task gate, 6 TSS, 7 busy TSS
   task automatic run_case(input int k, input int dpl, input int c, input logic p,
                           input logic o32, input int run);
      logic [15:0] sel = {13'(run * 7 + 1), run[1], 2'(run >> 2)};
      logic [15:0] gsel = {13'(run * 11 + 5), ~run[1], 2'(run)};
      logic [31:0] ioff = 32'hA500_0000 ^ (run * 32'h0101_0123);
      logic [31:0] goff = 32'h5A00_0000 ^ (run * 32'h0013_0011);
      logic        p2 = (run % 7) != 3;
      logic [1:0]  tdpl = 2'(run >> 3);
      logic [3:0]  ty2 = (run % 5 == 0) ? 4'h2 : (run[2] ? 4'hE : 4'hA);
      logic [3:0]  ty;
      logic        s;
      int          outcome;   // 0 jump, 1 task, 2 fault
      int          exp_nreq = 1;
      int          exp_lat;
      int          lat = 0;
      string       tag;
      case (k)
         0: begin s = 1; ty = 4'hA; end
         1: begin s = 1; ty = 4'hE; end
         2: begin s = 1; ty = 4'h2; end
         3: begin s = 0; ty = 4'h4; end
         4: begin s = 0; ty = 4'hC; end
         5: begin s = 0; ty = 4'h5; end
         6: begin s = 0; ty = run[0] ? 4'h9 : 4'h1; end
         default: begin s = 0; ty = 4'hB; end
      endcase
      cur_d[0] = mk_desc(p, 2'(dpl), s, ty, gsel, goff);
      cur_d[1] = mk_desc(p2, tdpl, 1'b1, ty2, 16'h0, 32'h0);
      delay = run % 3;
      // expected outcome from the requirements
      outcome = 2;
      tag = "R9";
      if (p) begin
         case (k)
            0, 1: begin
               tag = (k == 0) ? "R2" : "R4";
               if (code_ok(1'b1, 1'b1, ty, 2'(dpl), 2'(c))) begin
                  outcome = 0;
                  e_sel = {sel[15:2], 2'(c)};
                  e_off = o32 ? ioff : {16'h0, ioff[15:0]};
                  if (!o32) tag = "R3";
               end
            end
            3, 4: begin
               exp_nreq = 2;
               tag = "R6";
               if (code_ok(p2, 1'b1, ty2, tdpl, 2'(c))) begin
                  outcome = 0;
                  tag = "R5";
                  e_sel = {gsel[15:2], 2'(c)};
                  e_off = (k == 4) ? goff : {16'h0, goff[15:0]};
               end
            end
            5: begin outcome = 1; tag = "R7"; e_tss = gsel; end
            6: begin outcome = 1; tag = "R8"; e_tss = sel; end
            default: ;
         endcase
      end
      exp_lat = 3 + delay + ((exp_nreq == 2) ? 1 + delay : 0);

      @(negedge clk);
      nreq = 0;
      sel_in = sel; off_in = ioff; op32 = o32; cpl = 2'(c); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      sel_in = ~sel; off_in = ~ioff;
      lat = 1;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == exp_lat, "R11", "latency", 32'(lat), 32'(exp_lat));
      chk({jmp_load, task_req, fault} == ((outcome == 0) ? 3'b100 : (outcome == 1) ? 3'b010 : 3'b001),
          (outcome == 2) ? tag : "R10", "outcome flags",
          {29'h0, jmp_load, task_req, fault},
          (outcome == 0) ? 32'h4 : (outcome == 1) ? 32'h2 : 32'h1);
      chk(tgt_sel == e_sel, tag, "tgt_sel", {16'h0, tgt_sel}, {16'h0, e_sel});
      chk(tgt_off == e_off, tag, "tgt_off", tgt_off, e_off);
      chk(tss_sel == e_tss, tag, "tss_sel", {16'h0, tss_sel}, {16'h0, e_tss});
      chk(nreq == exp_nreq, "R5", "request count", 32'(nreq), 32'(exp_nreq));
      chk(req_loc[0] == sel[2] && req_idx[0] == sel[15:3], "R1", "first request",
          {18'h0, req_loc[0], req_idx[0]}, {18'h0, sel[2], sel[15:3]});
      if (exp_nreq == 2)
         chk(req_loc[1] == gsel[2] && req_idx[1] == gsel[15:3], "R5", "gate target request",
             {18'h0, req_loc[1], req_idx[1]}, {18'h0, gsel[2], gsel[15:3]});
      @(negedge clk);
      chk(!done && !jmp_load && !task_req && !fault, "R10", "pulse ended",
          {28'h0, done, jmp_load, task_req, fault}, 32'h0);
   endtask

   initial begin
      int run = 0;
      repeat (3) @(negedge clk);
      chk(!done && !dreq_valid && !jmp_load && !task_req && !fault, "R10", "reset outputs quiet",
          {27'h0, done, dreq_valid, jmp_load, task_req, fault}, 32'h0);
      chk(tgt_sel == 16'h0 && tgt_off == 32'h0 && tss_sel == 16'h0, "R9", "reset targets",
          tgt_off, 32'h0);
      rst_n = 1'b1;
      for (int k = 0; k < 8; k++)
         for (int d = 0; d < 4; d++)
            for (int c = 0; c < 4; c++)
               for (int pp = 0; pp < 2; pp++)
                  for (int o = 0; o < 2; o++) begin
                     run_case(k, d, c, pp[0], o[0], run);
                     run++;
                  end
      report();
   end
endmodule